// File: doc/BRIEF.md
# Four-Bit Lookahead Adder Slice

This block adds two 4-bit operands and a carry-in in one combinational stage. Every internal carry is a flat sum of products over the per-bit generate and propagate terms and the carry-in. No carry waits on the carry of the bit below it, so the depth from any input to any carry is the same for every bit position.

Besides the sum and the carry-out, the slice exports a group generate and a group propagate. The slice can therefore be used on its own as a 4-bit adder. It can also serve as a leaf under a higher lookahead level, which takes the group pair from each slice and returns the slice's carry-in. In that case the parent may ignore the slice's carry-out.

There is no clock and no reset. The outputs follow the inputs once the logic settles.

Top module: `cla4_slice`

## Requirements
- R1: `sum_o` equals bits [3:0] of the unsigned value `a_i + b_i + c_i`.
- R2: `c_o` equals bit 4 of the unsigned value `a_i + b_i + c_i`.
- R3: `grp_p_o` is 1 exactly when every bit position has at least one operand bit at 1, that is, when `a_i | b_i` is 4'b1111.
- R4: `grp_g_o` equals the carry out of `a_i + b_i` with the carry-in taken as 0.
- R5: `c_o` equals `grp_g_o | (grp_p_o & c_i)` for every input combination.
- R6: `grp_g_o` and `grp_p_o` do not depend on `c_i`. Toggling `c_i` with the operands held leaves both outputs unchanged.
- R7: The block is purely combinational. The outputs reflect new inputs without any clock edge, and all-zero inputs give all-zero outputs.
- R8: Every product or sum term in the carry logic has at most five inputs. Each carry is formed from the bit generate and propagate terms and the carry-in, never from an earlier carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | 4 | Sum bits |
| c_o | output | 1 | Carry out of bit 3 |
| grp_g_o | output | 1 | Group generate: the slice makes a carry by itself |
| grp_p_o | output | 1 | Group propagate: the slice passes an incoming carry through |

## Verification
All 512 combinations of both operands and the carry-in are applied. Each combination is compared against an integer addition, so every carry path and every sum bit is checked with the carry both present and absent.

Directed patterns then separate the group terms:
- Operands whose OR is all ones but which have no bit generate exercise pure propagation: the carry-out must follow the carry-in.
- Operands with a generate in the top bit only exercise generation: the carry-out is 1 regardless of the carry-in.
- Held operands with a toggled carry-in show that the group pair ignores the carry-in.

The carry-in toggles are applied without any clock edge in between, which shows the outputs are combinational.

// File: rtl/cla4_pkg.sv
package cla4_pkg;
  localparam int unsigned SLICE_W = 4;
  typedef logic [SLICE_W-1:0] slice_t;
endpackage

// File: rtl/cla4_bit_pg.sv
module cla4_bit_pg
  import cla4_pkg::*;
(
  input  slice_t a_i,
  input  slice_t b_i,
  output slice_t g_o,
  output slice_t p_o,
  output slice_t h_o
);
  for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
    assign g_o[i] = a_i[i] & b_i[i];
    assign p_o[i] = a_i[i] | b_i[i];
    // half-sum kept apart: an OR propagate cannot form the sum
    assign h_o[i] = a_i[i] ^ b_i[i];
  end
endmodule

// File: rtl/cla4_carry.sv
module cla4_carry
  import cla4_pkg::*;
(
  input  slice_t            g_i,
  input  slice_t            p_i,
  input  logic              c_i,
  output logic [SLICE_W:0]  c_o,
  output logic              grp_g_o,
  output logic              grp_p_o
);
  // flat two-level equations, fan-in <= 5
  assign c_o[0] = c_i;
  assign c_o[1] = g_i[0] | (p_i[0] & c_i);
  assign c_o[2] = g_i[1] | (p_i[1] & g_i[0]) | (p_i[1] & p_i[0] & c_i);
  assign c_o[3] = g_i[2] | (p_i[2] & g_i[1]) | (p_i[2] & p_i[1] & g_i[0])
                | (p_i[2] & p_i[1] & p_i[0] & c_i);
  assign c_o[4] = g_i[3] | (p_i[3] & g_i[2]) | (p_i[3] & p_i[2] & g_i[1])
                | (p_i[3] & p_i[2] & p_i[1] & g_i[0])
                | (p_i[3] & p_i[2] & p_i[1] & p_i[0] & c_i);

  assign grp_p_o = p_i[3] & p_i[2] & p_i[1] & p_i[0];
  assign grp_g_o = g_i[3] | (p_i[3] & g_i[2]) | (p_i[3] & p_i[2] & g_i[1])
                 | (p_i[3] & p_i[2] & p_i[1] & g_i[0]);
endmodule

// File: rtl/cla4_sum.sv
module cla4_sum
  import cla4_pkg::*;
(
  input  slice_t           h_i,
  input  logic [SLICE_W:0] c_i,
  output slice_t           sum_o
);
  for (genvar i = 0; i < SLICE_W; i++) begin : g_sum
    assign sum_o[i] = h_i[i] ^ c_i[i];
  end
endmodule

// File: rtl/cla4_slice.sv
module cla4_slice
  import cla4_pkg::*;
(
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       c_i,
  output logic [3:0] sum_o,
  output logic       c_o,
  output logic       grp_g_o,
  output logic       grp_p_o
);
  slice_t           g, p, h;
  logic [SLICE_W:0] cy;

  cla4_bit_pg u_pg (
    .a_i (a_i),
    .b_i (b_i),
    .g_o (g),
    .p_o (p),
    .h_o (h)
  );

  cla4_carry u_carry (
    .g_i     (g),
    .p_i     (p),
    .c_i     (c_i),
    .c_o     (cy),
    .grp_g_o (grp_g_o),
    .grp_p_o (grp_p_o)
  );

  cla4_sum u_sum (
    .h_i   (h),
    .c_i   (cy),
    .sum_o (sum_o)
  );

  assign c_o = cy[SLICE_W];
endmodule

// File: rtl/cla4_slice_chk.sv
module cla4_slice_chk (
  input logic [3:0] a_i,
  input logic [3:0] b_i,
  input logic       c_i,
  input logic [3:0] sum_o,
  input logic       c_o,
  input logic       grp_g_o,
  input logic       grp_p_o
);
  logic [4:0] ref_sum;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + {4'b0, c_i};

  always_comb begin
    AST_SUM_BITS: assert (sum_o == ref_sum[3:0]); // R1
    AST_CARRY_OUT: assert (c_o == ref_sum[4]); // R2
    AST_PROP_PASS: assert (!(grp_p_o && !grp_g_o) || (c_o == c_i)); // R3
    AST_GEN_FORCES: assert (!grp_g_o || c_o); // R4
    AST_GROUP_CARRY: assert (c_o == (grp_g_o | (grp_p_o & c_i))); // R5
  end
endmodule

bind cla4_slice cla4_slice_chk u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .c_i     (c_i),
  .sum_o   (sum_o),
  .c_o     (c_o),
  .grp_g_o (grp_g_o),
  .grp_p_o (grp_p_o)
);

// File: tb/tb_cla4_slice.sv
module tb_cla4_slice;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] a, b;
  logic       cin;
  logic [3:0] sum;
  logic       cout, gg, gp;
  int         n_checks = 0;
  int         n_errors = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cla4_slice dut (
    .a_i     (a),
    .b_i     (b),
    .c_i     (cin),
    .sum_o   (sum),
    .c_o     (cout),
    .grp_g_o (gg),
    .grp_p_o (gp)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: act=%0d exp=%0d (a=%0d b=%0d cin=%0d)", req, act, exp, a, b, cin);
    end
  endtask

  task automatic apply(input logic [3:0] av, input logic [3:0] bv, input logic cv);
    @(posedge clk);
    a = av; b = bv; cin = cv;
    @(negedge clk);
  endtask

  task automatic check_all();
    int tot = int'(a) + int'(b) + int'(cin);
    int g0 = (int'(a) + int'(b)) >> 4;
    int pp = ((a | b) == 4'hF) ? 1 : 0;
    check("R1", sum, tot & 15);
    check("R2", cout, (tot >> 4) & 1);
    check("R3", gp, pp);
    check("R4", gg, g0);
    check("R5", cout, g0 | (pp & cin));
  endtask

  task automatic t_zero();
    apply(4'h0, 4'h0, 1'b0);
    check("R7", {cout, gg, gp, sum}, 0);
  endtask

  task automatic t_exhaustive();
    for (int i = 0; i < 512; i++) begin
      apply(i[3:0], i[7:4], i[8]);
      check_all();
    end
  endtask

  task automatic t_propagate_only();
    // OR all ones, no generate: carry-out follows carry-in
    apply(4'b1010, 4'b0101, 1'b0);
    check("R3", gp, 1); check("R4", gg, 0); check("R2", cout, 0);
    apply(4'b1010, 4'b0101, 1'b1);
    check("R2", cout, 1); check("R1", sum, 0);
  endtask

  task automatic t_generate_top();
    apply(4'b1000, 4'b1000, 1'b0);
    check("R4", gg, 1); check("R3", gp, 0); check("R2", cout, 1);
    apply(4'b1000, 4'b1000, 1'b1);
    check("R2", cout, 1); check("R1", sum, 1);
  endtask

  task automatic t_cin_ignored_by_group();
    // toggle cin without a clock edge: group pair steady, sum moves
    for (int i = 0; i < 256; i += 37) begin
      logic g_ref, p_ref;
      apply(i[3:0], i[7:4], 1'b0);
      g_ref = gg; p_ref = gp;
      #1 cin = 1'b1;
      #1;
      check("R6", gg, g_ref);
      check("R6", gp, p_ref);
      check("R7", sum, (int'(a) + int'(b) + 1) & 15);
    end
  endtask

  task automatic t_flat_carry();
    // longest chain: g0 with p1..p3 set carries to c4
    apply(4'b1111, 4'b0001, 1'b0);
    check("R8", cout, 1); check("R8", sum, 0);
    apply(4'b0111, 4'b0001, 1'b0);
    check("R8", cout, 0); check("R8", sum, 8);
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    t_zero();
    t_exhaustive();
    t_propagate_only();
    t_generate_top();
    t_cin_ignored_by_group();
    t_flat_carry();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: act=timeout exp=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule